// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

The aligner connects a core's load/store path to a data memory that is 32 bits wide and addressed in bytes. For each request it adds a sign-extended 16-bit displacement to a 32-bit base. It then produces the word address for the memory and checks that the access sits on its natural boundary. For stores it also produces a four-bit byte-enable mask and write data with the value placed in its lanes. Lanes are big-endian: the byte at the lowest address of a word occupies bits 31:24.

For loads, the block registers the low address bits, the access size and the extension mode when the request is accepted. In the next cycle the memory returns the addressed word. From that word and the registered context, the block picks out the byte, halfword or word and extends it to 32 bits, with sign or zero extension as the request asked. A request that is not naturally aligned raises an address-error flag, and no byte is enabled for it.

Top module: `lane_aligner`

## Requirements
- R1: The effective address is base plus the 16-bit displacement sign-extended to 32 bits. The memory address equals that sum with its two low bits forced to zero, and a carry out of the low bits reaches the word address.
- R2: Lane mapping is big-endian. Effective-address bits 1:0 equal to 0, 1, 2, 3 select data bits 31:24, 23:16, 15:8, 7:0 and byte-enable bits 3, 2, 1, 0 respectively.
- R3: The size code is 0 for byte, 1 for halfword, and 2 or 3 for word. A byte store enables exactly the addressed lane and repeats bits 7:0 of the store data in all four lanes.
- R4: A halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2, and repeats data bits 15:0 in both halves. A word store enables 4'b1111 and passes the data unchanged.
- R5: With a valid request, address error is high for a halfword whose effective-address bit 0 is set and for a word whose effective-address bits 1:0 are nonzero. Byte enables are then all zero.
- R6: A load request never asserts any byte enable. Address error is also low when no request is valid.
- R7: A valid, aligned load (store flag low) registers its size, extension mode and offset at the clock edge. The load result is formed from the memory word presented after that edge. After reset the context is word size at offset 0, so the result equals the memory word.
- R8: With the unsigned flag low, byte and halfword loads copy the selected field's top bit into all upper result bits.
- R9: With the unsigned flag high, byte and halfword loads fill the upper result bits with zeros. Word loads return the whole word whatever the flag.
- R10: A misaligned load, a store, or an idle cycle leaves the registered load context unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Register value to store |
| mem_addr | output | 32 | Word address, low two bits zero |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-positioned store data |
| addr_err | output | 1 | Misaligned access |
| mem_rdata | input | 32 | Word returned by memory the cycle after a load |
| load_result | output | 32 | Extracted and extended load value |

## Verification
Several properties are checked by assertions on every cycle. The word address always has zero low bits. An address error always leaves the enables empty, and loads never enable a byte. An enabled byte store drives exactly one lane, and a halfword store drives two adjacent lanes. The registered context holds on every cycle without an aligned load, and zero-extended narrow results have clean upper bits. Other behaviour can only be shown by the bench's scenarios, which compare exact values: which lane a given offset selects, the replicated data patterns, sign extension of negative bytes and halfwords, the carry from the displacement into the word address, and the result after reset or after a rejected load.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_B  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef struct packed {
    size_e            size;
    logic             zext;
    logic [OFF_B-1:0] off;
  } ld_ctx_t;

  function automatic logic is_word(input size_e s);
    return (s == SZ_WORD) || (s == SZ_WALT);
  endfunction

  function automatic logic misaligned(input size_e s, input logic [OFF_B-1:0] off);
    if (s == SZ_HALF) return off[0];
    if (is_word(s))   return off != '0;
    return 1'b0;
  endfunction

  // Lane i is byte-enable bit i; byte address offset k uses lane LANES-1-k.
  function automatic logic [LANES-1:0] lane_mask(input size_e s, input logic [OFF_B-1:0] off);
    logic [LANES-1:0] m;
    m = '0;
    if (s == SZ_BYTE)      m[LANES-1-off] = 1'b1;
    else if (s == SZ_HALF) m = off[1] ? 4'b0011 : 4'b1100;
    else                   m = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] replicate(input size_e s, input logic [DATA_W-1:0] d);
    if (s == SZ_BYTE) return {LANES{d[7:0]}};
    if (s == SZ_HALF) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] extract(input ld_ctx_t c, input logic [DATA_W-1:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*(LANES-1-c.off) +: 8];
    h = c.off[1] ? w[15:0] : w[31:16];
    if (c.size == SZ_BYTE) return {{(DATA_W-8){b[7] & ~c.zext}}, b};
    if (c.size == SZ_HALF) return {{(DATA_W-16){h[15] & ~c.zext}}, h};
    return w;
  endfunction
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  size_e             size,
  input  logic              valid,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFF_B-1:0]  off,
  output logic              bad_align
);
  logic [ADDR_W-1:0] ea;

  always_comb begin
    ea        = base + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    off       = ea[OFF_B-1:0];
    word_addr = {ea[ADDR_W-1:OFF_B], {OFF_B{1'b0}}};
    bad_align = valid && misaligned(size, off);
  end

  a_r1_word_addr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    word_addr[OFF_B-1:0] == '0);
  a_r5_byte_never_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_BYTE) |-> !bad_align);
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  size_e             size,
  input  logic [OFF_B-1:0]  off,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  always_comb begin
    be    = wr_en ? lane_mask(size, off) : '0;
    wdata = replicate(size, data);
  end

  a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_BYTE) |-> $countones(be) == 1);
  a_r4_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_HALF) |-> (be == 4'b1100 || be == 4'b0011));
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  ld_ctx_t           ctx_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  localparam ld_ctx_t CTX_RST = '{size: SZ_WORD, zext: 1'b0, off: '0};
  ld_ctx_t ctx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctx_q <= CTX_RST;
    else if (capture) ctx_q <= ctx_in;
  end

  always_comb result = extract(ctx_q, rdata);

  a_r10_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ctx_q));
  a_r9_zext_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.zext && ctx_q.size == SZ_BYTE) |-> result[DATA_W-1:8] == '0);
  a_r9_zext_half: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.zext && ctx_q.size == SZ_HALF) |-> result[DATA_W-1:16] == '0);
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              addr_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_result
);
  size_e            size;
  logic [OFF_B-1:0] off;
  logic             bad_align;
  logic             store_go;
  logic             load_go;
  ld_ctx_t          ctx_new;

  always_comb begin
    size     = size_e'(req_size);
    store_go = req_valid && req_store && !bad_align;
    load_go  = req_valid && !req_store && !bad_align;
    ctx_new  = '{size: size, zext: req_unsigned, off: off};
    addr_err = bad_align;
  end

  lsa_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .base(req_base), .disp(req_disp), .size(size),
    .valid(req_valid), .word_addr(mem_addr), .off(off), .bad_align(bad_align)
  );

  lsa_store_lanes u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_go), .size(size), .off(off),
    .data(req_wdata), .be(mem_be), .wdata(mem_wdata)
  );

  lsa_load_extract u_load (
    .clk(clk), .rst_n(rst_n), .capture(load_go), .ctx_in(ctx_new),
    .rdata(mem_rdata), .result(load_result)
  );

  a_r5_err_blocks_be: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> mem_be == '0);
  a_r6_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_store) |-> mem_be == '0);
  a_r6_idle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !addr_err);
endmodule

// File: tb/test_lane_aligner.sv
module test_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_base = '0, req_wdata = '0, mem_rdata = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] mem_addr, mem_wdata, load_result;
  logic [3:0]  mem_be;
  logic        addr_err;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  lane_aligner i_lane_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_disp(req_disp), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .addr_err(addr_err),
    .mem_rdata(mem_rdata), .load_result(load_result)
  );

  typedef struct packed {
    logic st; logic [1:0] sz; logic un;
    logic [31:0] base; logic [15:0] disp; logic [31:0] data;
    logic [3:0] be; logic [31:0] out; logic err;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h1000, 16'h0001, 32'h000000AB, 4'b0100, 32'hABABABAB, 1'b0},
    '{1'b1, 2'd0, 1'b1, 32'h1000, 16'h0003, 32'h12345678, 4'b0001, 32'h78787878, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h2000, 16'h0002, 32'hCAFEBEEF, 4'b0011, 32'hBEEFBEEF, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h2000, 16'h0000, 32'hCAFEBEEF, 4'b1100, 32'hBEEFBEEF, 1'b0},
    '{1'b1, 2'd2, 1'b0, 32'h3000, 16'hFFFC, 32'h11223344, 4'b1111, 32'h11223344, 1'b0},
    '{1'b1, 2'd3, 1'b0, 32'h3000, 16'h0008, 32'h55667788, 4'b1111, 32'h55667788, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h2000, 16'h0001, 32'h0000FFFF, 4'b0000, 32'h0,        1'b1},
    '{1'b1, 2'd2, 1'b0, 32'h3000, 16'h0002, 32'h01020304, 4'b0000, 32'h0,        1'b1},
    '{1'b0, 2'd0, 1'b0, 32'h0100, 16'h0000, 32'h80FF7F01, 4'b0000, 32'hFFFFFF80, 1'b0},
    '{1'b0, 2'd0, 1'b1, 32'h0100, 16'h0000, 32'h80FF7F01, 4'b0000, 32'h00000080, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h0100, 16'h0002, 32'h80FF7F01, 4'b0000, 32'h0000007F, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h0100, 16'h0001, 32'h80FF7F01, 4'b0000, 32'hFFFFFFFF, 1'b0},
    '{1'b0, 2'd0, 1'b1, 32'h0100, 16'h0003, 32'h80FF7F01, 4'b0000, 32'h00000001, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h0100, 16'h0000, 32'h80FF7F01, 4'b0000, 32'hFFFF80FF, 1'b0},
    '{1'b0, 2'd1, 1'b1, 32'h0100, 16'h0000, 32'h80FF7F01, 4'b0000, 32'h000080FF, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h0100, 16'h0002, 32'h80FF7F01, 4'b0000, 32'h00007F01, 1'b0},
    '{1'b0, 2'd2, 1'b1, 32'h0108, 16'hFFF8, 32'h80FF7F01, 4'b0000, 32'h80FF7F01, 1'b0},
    '{1'b0, 2'd2, 1'b0, 32'h0100, 16'h0001, 32'h80FF7F01, 4'b0000, 32'h0,        1'b1},
    '{1'b1, 2'd0, 1'b0, 32'h1FFF, 16'h0001, 32'h000000C3, 4'b1000, 32'hC3C3C3C3, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic un,
                       input logic [31:0] base, input logic [15:0] disp, input logic [31:0] d);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = un;
    req_base = base; req_disp = disp; req_wdata = d;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mem_rdata = 32'hDEADBEEF;
    #20;
    // R7: reset context is word at offset 0; R6: idle gives no enable, no error
    chk("R7 reset result", load_result, 32'hDEADBEEF);
    chk("R6 reset be", {28'd0, mem_be}, 32'd0);
    chk("R6 reset err", {31'd0, addr_err}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].st, VECS[i].sz, VECS[i].un, VECS[i].base, VECS[i].disp, VECS[i].data);
      #3;
      chk("R1 word address", mem_addr,
          (VECS[i].base + {{16{VECS[i].disp[15]}}, VECS[i].disp}) & ~32'h3);
      chk("R2 R5 R6 byte enables", {28'd0, mem_be}, {28'd0, VECS[i].be});
      chk("R5 address error", {31'd0, addr_err}, {31'd0, VECS[i].err});
      if (VECS[i].st && !VECS[i].err)
        chk("R3 R4 store lanes", mem_wdata, VECS[i].out);
      if (!VECS[i].st && !VECS[i].err) begin
        @(negedge clk);
        req_valid = 1'b0; mem_rdata = VECS[i].data;
        #3;
        chk("R8 R9 load result", load_result, VECS[i].out);
      end
    end

    // R10: misaligned load and a store do not replace the registered context
    @(negedge clk); drive(1'b0, 2'd0, 1'b1, 32'h0100, 16'h0003, 32'h0);
    @(negedge clk); drive(1'b0, 2'd1, 1'b0, 32'h0100, 16'h0001, 32'h0);
    #3; chk("R10 rejected load err", {31'd0, addr_err}, 32'd1);
    @(negedge clk); drive(1'b1, 2'd2, 1'b0, 32'h0200, 16'h0000, 32'hFFFFFFFF);
    @(negedge clk); req_valid = 1'b0; mem_rdata = 32'hA1B2C3D4;
    @(negedge clk); #3;
    chk("R10 context kept", load_result, 32'h000000D4);

    // R7: reset mid-run returns the context to word
    rst_n = 1'b0; #2;
    chk("R7 reset restores word", load_result, 32'hA1B2C3D4);
    @(negedge clk); rst_n = 1'b1;

    // R6: idle request with misaligned fields flags nothing
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2; req_disp = 16'h0003;
    #3;
    chk("R6 idle err", {31'd0, addr_err}, 32'd0);
    chk("R6 idle be", {28'd0, mem_be}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule